// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from three sources in a small 8-bit microcontroller: a USB event and the overflows of two timer/event counters. It gives the core the vector address of the request to service. Each event arrives as a single-cycle pulse and sets a sticky request flag. The flags live in one shared control register, together with a master enable and one enable bit per source. The core reaches that register through a simple read/write port at data address 0x0B.

Pending requests are evaluated only at a rising edge of an instruction-phase strobe. At such an edge the block looks for requests that are flagged, enabled and allowed by the master enable. If there is one, it picks the winner by fixed priority, pulses a vector-valid output for one cycle and presents the winner's vector address. In the same step it clears the master enable, so that interrupts do not nest. The core then raises an acknowledge when servicing starts. The acknowledge clears the flag of the granted source and lets the block grant again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, vec_valid is low, and no service happens until the register is written.
- R2: The control register sits at reg_addr 0x0B. Bit 0 is the master enable. Bits 1, 2 and 3 enable USB, timer 0 and timer 1. Bits 4, 5 and 6 are the request flags of USB, timer 0 and timer 1. Bit 7 is reserved: it reads 0 and a write to it has no effect. Any other address reads 0x00, and a write to it changes nothing.
- R3: A one-cycle event pulse sets its source's flag on the next clock. The flag then stays set until that source's service is acknowledged or software writes the bit to 0.
- R4: If a register write clears a flag in the same cycle as a new event for that source, the flag is set afterwards.
- R5: Service is decided only in the clock cycle in which phase_stb is high after having been low in the previous cycle. vec_valid is high in the cycle that follows. An event that arrives in the edge cycle itself is serviced at the next strobe edge, not this one.
- R6: With the master enable at 0, no source is serviced, and request flags are still recorded.
- R7: A source whose enable bit is 0 is not serviced. The other enabled sources are still serviced.
- R8: Among the eligible requests the winner is fixed by priority: USB (vector 0x0C) first, then timer 0 (vector 0x04), then timer 1 (vector 0x08). vec_addr carries the winner's vector while vec_valid is high.
- R9: A service raises vec_valid for exactly one cycle and clears the master enable. After a grant, no further grant occurs until svc_ack is seen.
- R10: svc_ack after a grant clears only the granted source's flag. svc_ack with no grant outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_stb | input | 1 | Instruction-phase strobe; its rising edge is the service point |
| ev_usb | input | 1 | USB event pulse |
| ev_tmr0 | input | 1 | Timer 0 overflow pulse |
| ev_tmr1 | input | 1 | Timer 1 overflow pulse |
| reg_addr | input | 8 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| svc_ack | input | 1 | Core has started servicing the granted interrupt |
| vec_valid | output | 1 | One-cycle pulse marking a new vector |
| vec_addr | output | 8 | Vector address of the granted source |

## Verification
The bench raises all three requests together and then drains them one by one. A priority or vector table error shows up as the wrong address, or as the wrong order of addresses. It drives an event in the same cycle as a strobe edge. A design that samples the flags after the update would grant one edge too early. It collides a software flag clear with a new event, which a clear-wins flag would lose. It also re-enables the master bit before the acknowledge and sends an acknowledge with nothing outstanding. A design that grants twice, or clears flags on a stray acknowledge, fails on the read-back.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam int NSRC  = 3;
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  // field positions inside the control word
  localparam int B_MEN = 0;
  localparam int B_EN  = 1;
  localparam int B_FLG = B_EN + NSRC;
  localparam int CTRL_USED = B_FLG + NSRC;

  typedef enum logic [IDX_W-1:0] {
    SRC_USB  = 2'd0,
    SRC_TMR0 = 2'd1,
    SRC_TMR1 = 2'd2
  } src_e;

  // vector address for a source index; index 0 is the highest priority
  function automatic logic [7:0] src_vector(input logic [IDX_W-1:0] idx);
    logic [7:0] v;
    case (idx)
      SRC_USB:  v = 8'h0C;
      SRC_TMR0: v = 8'h04;
      SRC_TMR1: v = 8'h08;
      default:  v = 8'h00;
    endcase
    return v;
  endfunction

  // one-hot decode of a source index
  function automatic logic [NSRC-1:0] idx_onehot(input logic [IDX_W-1:0] idx);
    logic [NSRC-1:0] oh;
    oh = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (idx == IDX_W'(i)) oh[i] = 1'b1;
    end
    return oh;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_ctl_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         wr_en,
  input  logic [N-1:0] wr_flags,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags_q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic base;
    logic nxt;

    always_comb begin
      base = wr_en ? wr_flags[i] : flags_q[i];
      nxt  = ev[i] | (base & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= nxt;
    end

    // R4: an event is never lost, whatever the write or clear did
    a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> flags_q[i]);

    // R3: with no write and no clear, a set flag stays set
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !wr_en && !clr[i]) |=> flags_q[i]);
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_ctl_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = IDX_W
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] win_idx,
  output logic [N-1:0] win_oh
);

  // lowest index wins: scan from the bottom of the order upward
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any     = 1'b1;
        win_idx = W'(i);
      end
    end
    win_oh = any ? idx_onehot(win_idx) : '0;
  end

  // R8: at most one winner, and it is a requesting source
  always_comb begin
    a_r8_single_winner: assert ($onehot0(win_oh));
    a_r8_winner_requested: assert ((win_oh & ~req) == '0);
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_stb,
  input  logic              ev_usb,
  input  logic              ev_tmr0,
  input  logic              ev_tmr1,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              svc_ack,
  output logic              vec_valid,
  output logic [7:0]        vec_addr
);

  localparam int RSVD_W = DATA_W - CTRL_USED;

  // named internal events
  logic            addr_hit;
  logic            wr_hit;
  logic            stb_q;
  logic            stb_rise;
  logic            men_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] flags_q;
  logic [NSRC-1:0] ev_vec;
  logic [NSRC-1:0] eligible;
  logic [NSRC-1:0] ack_clr;
  logic            pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [NSRC-1:0] pick_oh;
  logic            svc_fire;
  logic            busy_q;
  logic [IDX_W-1:0] gnt_idx_q;
  logic            vec_valid_q;
  logic [7:0]      vec_addr_q;
  logic            rsvd_written;

  assign ev_vec   = {ev_tmr1, ev_tmr0, ev_usb};
  assign addr_hit = (reg_addr == ADDR_W'(CTRL_ADDR));
  assign wr_hit   = reg_wr & addr_hit;
  assign stb_rise = phase_stb & ~stb_q;
  assign eligible = flags_q & en_q & {NSRC{men_q}};
  assign svc_fire = stb_rise & ~busy_q & pick_any;
  assign ack_clr  = (svc_ack & busy_q) ? idx_onehot(gnt_idx_q) : '0;
  assign rsvd_written = wr_hit & (|reg_wdata[DATA_W-1:CTRL_USED]);

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_vec),
    .wr_en    (wr_hit),
    .wr_flags (reg_wdata[B_FLG +: NSRC]),
    .clr      (ack_clr),
    .flags_q  (flags_q)
  );

  irq_prio_pick #(.N(NSRC), .W(IDX_W)) u_pick (
    .req     (eligible),
    .any     (pick_any),
    .win_idx (pick_idx),
    .win_oh  (pick_oh)
  );

  // strobe edge detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= phase_stb;
  end

  // enables; a grant overrides a same-cycle write of the master bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (wr_hit) en_q <= reg_wdata[B_EN +: NSRC];
      if (svc_fire)    men_q <= 1'b0;
      else if (wr_hit) men_q <= reg_wdata[B_MEN];
    end
  end

  // grant tracking and vector output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      gnt_idx_q   <= '0;
      vec_valid_q <= 1'b0;
      vec_addr_q  <= '0;
    end else begin
      vec_valid_q <= svc_fire;
      if (svc_fire) begin
        busy_q     <= 1'b1;
        gnt_idx_q  <= pick_idx;
        vec_addr_q <= src_vector(pick_idx);
      end else if (svc_ack) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (addr_hit) begin
      reg_rdata[B_MEN]         = men_q;
      reg_rdata[B_EN +: NSRC]  = en_q;
      reg_rdata[B_FLG +: NSRC] = flags_q;
    end
  end

  assign vec_valid = vec_valid_q;
  assign vec_addr  = vec_addr_q;

  // R5: a vector only follows a strobe rising edge
  a_r5_vec_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_q |-> $past(stb_rise));

  // R6: a vector only when the master enable was on
  a_r6_master_needed: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_q |-> $past(men_q));

  // R9: one-cycle pulse, master cleared
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_q |=> !vec_valid_q);
  a_r9_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_q |-> !men_q);
  a_r9_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !svc_ack) |=> !vec_valid_q);

  // R8: vector matches the source recorded for the grant
  a_r8_vector_match: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_q |-> (vec_addr_q == src_vector(gnt_idx_q)));

  // R10: acknowledge clears the granted flag unless re-raised or rewritten
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && busy_q && !ev_vec[gnt_idx_q] && !wr_hit) |=> !flags_q[$past(gnt_idx_q)]);

  // R2: a reserved-bit write leaves the reserved read-back at zero
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_written |=> (reg_rdata[DATA_W-1 -: RSVD_W] == '0));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_stb = 1'b0;
  logic       ev_usb = 1'b0, ev_tmr0 = 1'b0, ev_tmr1 = 1'b0;
  logic [7:0] reg_addr = 8'h0B;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       svc_ack = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb),
    .ev_usb(ev_usb), .ev_tmr0(ev_tmr0), .ev_tmr1(ev_tmr1),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .svc_ack(svc_ack),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 8'h0B;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata; reg_addr = 8'h0B;
  endtask

  task automatic pulse_ev(input logic [2:0] m);
    @(negedge clk); {ev_tmr1, ev_tmr0, ev_usb} = m;
    @(negedge clk); {ev_tmr1, ev_tmr0, ev_usb} = 3'b000;
  endtask

  task automatic ack();
    @(negedge clk); svc_ack = 1'b1;
    @(negedge clk); svc_ack = 1'b0;
  endtask

  // one strobe edge; returns whether a vector came and its address
  task automatic strobe(output logic got, output logic [7:0] va);
    @(negedge clk); phase_stb = 1'b1;
    @(negedge clk); phase_stb = 1'b0; got = vec_valid; va = vec_addr;
    @(negedge clk);
    if (got) check("R9", "pulse width", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(8'h0B, d);
    check("R1", "reset read", d, 8'h00);
    check("R1", "reset vec_valid", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr_reg(8'h0B, 8'hFF);
    rd_reg(8'h0B, d);
    check("R2", "reserved bit read", d, 8'h7F);
    wr_reg(8'h0B, 8'h00);
    wr_reg(8'h0A, 8'h0F);
    rd_reg(8'h0B, d);
    check("R2", "foreign address write", d, 8'h00);
    wr_reg(8'h0B, 8'h0E);
    rd_reg(8'h0C, d);
    check("R2", "foreign address read", d, 8'h00);
    wr_reg(8'h0B, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    pulse_ev(3'b001);
    rd_reg(8'h0B, d);
    check("R3", "usb flag set", d, 8'h10);
    repeat (5) @(negedge clk);
    rd_reg(8'h0B, d);
    check("R3", "usb flag held", d, 8'h10);
    wr_reg(8'h0B, 8'h00);
    rd_reg(8'h0B, d);
    check("R3", "flag written to zero", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse_ev(3'b010);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h00; ev_tmr0 = 1'b1;
    @(negedge clk); reg_wr = 1'b0; ev_tmr0 = 1'b0;
    rd_reg(8'h0B, d);
    check("R4", "clear vs event", d, 8'h20);
    wr_reg(8'h0B, 8'h00);
  endtask

  task automatic t_master();
    logic g; logic [7:0] va, d;
    wr_reg(8'h0B, 8'h0E);
    pulse_ev(3'b001);
    strobe(g, va);
    check("R6", "master off no vector", {7'd0, g}, 8'h00);
    rd_reg(8'h0B, d);
    check("R6", "flag still recorded", d, 8'h1E);
  endtask

  task automatic t_per_src();
    logic g; logic [7:0] va, d;
    wr_reg(8'h0B, 8'h1D);
    strobe(g, va);
    check("R7", "disabled usb not served", {7'd0, g}, 8'h00);
    pulse_ev(3'b100);
    strobe(g, va);
    check("R7", "enabled tmr1 served", {7'd0, g}, 8'h01);
    check("R8", "tmr1 vector", va, 8'h08);
    rd_reg(8'h0B, d);
    check("R9", "master cleared on service", d, 8'h5C);
    wr_reg(8'h0B, 8'h5D);
    strobe(g, va);
    check("R9", "no regrant before ack", {7'd0, g}, 8'h00);
    ack();
    rd_reg(8'h0B, d);
    check("R10", "ack clears only tmr1", d, 8'h1D);
    wr_reg(8'h0B, 8'h00);
  endtask

  task automatic t_priority();
    logic g; logic [7:0] va, d;
    wr_reg(8'h0B, 8'h0F);
    pulse_ev(3'b111);
    strobe(g, va);
    check("R8", "first winner", va, 8'h0C);
    ack();
    rd_reg(8'h0B, d);
    check("R10", "usb cleared after ack", d, 8'h6E);
    wr_reg(8'h0B, 8'h6F);
    strobe(g, va);
    check("R8", "second winner", va, 8'h04);
    ack();
    rd_reg(8'h0B, d);
    check("R10", "tmr0 cleared after ack", d, 8'h4E);
    wr_reg(8'h0B, 8'h4F);
    strobe(g, va);
    check("R8", "third winner", va, 8'h08);
    check("R8", "third valid", {7'd0, g}, 8'h01);
    ack();
    rd_reg(8'h0B, d);
    check("R10", "all drained", d, 8'h0E);
  endtask

  task automatic t_edge();
    logic g; logic [7:0] va;
    wr_reg(8'h0B, 8'h0F);
    @(negedge clk); phase_stb = 1'b1; ev_usb = 1'b1;
    @(negedge clk); phase_stb = 1'b0; ev_usb = 1'b0;
    check("R5", "edge-cycle event not served", {7'd0, vec_valid}, 8'h00);
    repeat (3) @(negedge clk);
    check("R5", "no vector between edges", {7'd0, vec_valid}, 8'h00);
    strobe(g, va);
    check("R5", "served at next edge", {7'd0, g}, 8'h01);
    check("R8", "usb vector", va, 8'h0C);
    ack();
    wr_reg(8'h0B, 8'h00);
  endtask

  task automatic t_ack_idle();
    logic [7:0] d;
    wr_reg(8'h0B, 8'h24);
    ack();
    rd_reg(8'h0B, d);
    check("R10", "stray ack no effect", d, 8'h24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_sticky();
    t_collide();
    t_master();
    t_per_src();
    t_priority();
    t_edge();
    t_ack_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule